// File: doc/BRIEF.md
# Gain Coefficient Bank with Guarded Software Writes

This block keeps one gain coefficient per converter channel, three channels by default, each 16 bits wide. While reset is held, every coefficient loads a per-part preset value that arrives on an input bus. After reset, two sources can change a coefficient. A register-bus write changes it only under safe conditions. A calibration-complete strobe from the converter changes it at any time.

A software write is taken only when three things hold. The converter must be enabled. It must be in idle mode. It must have stayed enabled and idle for a minimum dwell time. The dwell time is given in nanoseconds and is turned into a cycle count from the clock rate. A cycle counter measures the dwell, and it restarts whenever the enabled-and-idle qualifier drops. A write that is turned away leaves every coefficient as it was and raises a one-cycle error pulse. A calibration result always lands in its channel and beats a software write aimed at the same channel in the same cycle.

Top module: `gain_cal_guard`

## Requirements
- R1: While `rst_n` is low at a clock edge, each channel's coefficient loads its slice of `preset_i` (channel c at bits c*16 +: 16), and `wr_err_o` is low after that edge.
- R2: `rd_data_o` shows, combinationally, the coefficient of the channel chosen by `rd_sel_i`. A select value of NUM_CH or above reads as zero. `coef_o` carries all coefficients, with channel c at bits c*16 +: 16.
- R3: An accepted write puts `wr_data_i` into channel `wr_sel_i` at the clock edge. The other channels keep their values, and `wr_err_o` stays low after that edge.
- R4: If `wr_en_i` is high while `cnv_en_i` or `cnv_idle_i` is low, the write is rejected. No coefficient changes, and `wr_err_o` is high for exactly the one cycle after that edge.
- R5: A write is accepted only if the qualifier (`cnv_en_i` and `cnv_idle_i` both high) was high at the DWELL_CYC consecutive clock edges before the write's edge and is still high at the write's edge. DWELL_CYC = ceil(CLK_KHZ*DWELL_NS/1e6).
- R6: A single cycle with the qualifier low restarts the dwell count from zero.
- R7: A high bit c of `cal_done_i` loads channel c from its slice of `cal_data_i` at that edge, whatever the qualifier or dwell state.
- R8: If a calibration and a software write target the same channel in the same cycle, the calibration value is stored, the write is dropped, and `wr_err_o` pulses.
- R9: A write with `wr_sel_i` of NUM_CH or above is rejected with a `wr_err_o` pulse and changes no coefficient.
- R10: A calibration on one channel and an accepted write to another channel in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the presets |
| preset_i | input | NUM_CH*16 | Per-part default coefficients |
| cnv_en_i | input | 1 | Converter enabled |
| cnv_idle_i | input | 1 | Converter in idle mode |
| wr_en_i | input | 1 | Register-bus write strobe |
| wr_sel_i | input | SW | Channel addressed by the write |
| wr_data_i | input | 16 | Write data |
| cal_done_i | input | NUM_CH | Per-channel calibration-complete strobes |
| cal_data_i | input | NUM_CH*16 | Per-channel calibration results |
| rd_sel_i | input | SW | Channel chosen for readback |
| rd_data_o | output | 16 | Readback of the chosen coefficient |
| coef_o | output | NUM_CH*16 | All coefficients |
| wr_err_o | output | 1 | One-cycle pulse for a rejected write |

## Verification
The in-RTL properties check four things on every cycle. The dwell counter clears after any low qualifier and never counts past its limit. Each coefficient holds unless a calibration or accepted-write event hits it. A calibration always stores its result, and the write guard never grants a write on a channel being calibrated. The error flag follows a refused write and is low after a cycle with no write. The bench scenarios cover the rest. They set the exact boundary of the dwell in cycles, show that a one-cycle drop forces a full restart, and check the preset load, the readback mux and its out-of-range value. They also check the same-channel and cross-channel collisions as the values seen at the ports.

// File: rtl/gcb_pkg.sv
package gcb_pkg;

  // Cycles needed to cover a dwell given in ns at a clock given in kHz, rounded up.
  function automatic int unsigned dwell_cycles(input int unsigned clk_khz,
                                               input int unsigned dwell_ns);
    longint unsigned prod;
    prod = longint'(clk_khz) * longint'(dwell_ns);
    return int'((prod + 64'd999_999) / 64'd1_000_000);
  endfunction

  // Grant rule for a software write.
  function automatic logic write_allowed(input logic qual,
                                         input logic dwell_ok,
                                         input logic sel_ok,
                                         input logic cal_clash);
    return qual & dwell_ok & sel_ok & ~cal_clash;
  endfunction

endpackage

// File: rtl/gcb_dwell_timer.sv
module gcb_dwell_timer #(
  parameter int unsigned DWELL_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic qual_i,
  output logic dwell_ok_o
);
  localparam int unsigned CW = $clog2(DWELL_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DWELL_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (!qual_i)      cnt <= '0;
    else if (cnt < LIMIT)  cnt <= cnt + 1'b1;
  end

  assign dwell_ok_o = (cnt == LIMIT);

  a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !qual_i |=> (cnt == '0));
  a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIMIT);
  a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_i && !dwell_ok_o) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/gcb_write_guard.sv
module gcb_write_guard #(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned SW     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [SW-1:0]     wr_sel_i,
  input  logic              qual_i,
  input  logic              dwell_ok_i,
  input  logic [NUM_CH-1:0] cal_done_i,
  output logic [NUM_CH-1:0] wr_hit_o,
  output logic              wr_err_o
);
  import gcb_pkg::*;

  logic sel_ok;
  logic cal_clash;
  logic accept;

  assign sel_ok = ({1'b0, wr_sel_i} < (SW+1)'(NUM_CH));

  always_comb begin
    cal_clash = 1'b0;
    for (int i = 0; i < int'(NUM_CH); i++) begin
      if (wr_sel_i == SW'(i)) cal_clash = cal_done_i[i];
    end
  end

  assign accept = wr_en_i & write_allowed(qual_i, dwell_ok_i, sel_ok, cal_clash);

  for (genvar g = 0; g < int'(NUM_CH); g++) begin : g_hit
    assign wr_hit_o[g] = accept && (wr_sel_i == SW'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wr_err_o <= 1'b0;
    else        wr_err_o <= wr_en_i & ~accept;
  end

  a_r4_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && (wr_hit_o == '0)) |=> wr_err_o);
  a_r3_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i || (wr_hit_o != '0)) |=> !wr_err_o);
  a_r3_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit_o));
  a_r8_no_grant_on_cal: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit_o & cal_done_i) == '0);
  a_r5_needs_dwell: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit_o != '0) |-> (qual_i && dwell_ok_i));
endmodule

// File: rtl/gcb_coef_reg.sv
module gcb_coef_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] preset_i,
  input  logic         cal_done_i,
  input  logic [W-1:0] cal_data_i,
  input  logic         wr_hit_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] coef_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)          coef_o <= preset_i;
    else if (cal_done_i) coef_o <= cal_data_i;
    else if (wr_hit_i)   coef_o <= wr_data_i;
  end

  a_r7_cal_load: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done_i |=> (coef_o == $past(cal_data_i)));
  a_r3_wr_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit_i && !cal_done_i) |=> (coef_o == $past(wr_data_i)));
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit_i && !cal_done_i) |=> $stable(coef_o));
endmodule

// File: rtl/gain_cal_guard.sv
module gain_cal_guard #(
  parameter int unsigned NUM_CH   = 3,
  parameter int unsigned CLK_KHZ  = 20480,
  parameter int unsigned DWELL_NS = 23000,
  localparam int unsigned W  = 16,
  localparam int unsigned SW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CH*W-1:0] preset_i,
  input  logic                cnv_en_i,
  input  logic                cnv_idle_i,
  input  logic                wr_en_i,
  input  logic [SW-1:0]       wr_sel_i,
  input  logic [W-1:0]        wr_data_i,
  input  logic [NUM_CH-1:0]   cal_done_i,
  input  logic [NUM_CH*W-1:0] cal_data_i,
  input  logic [SW-1:0]       rd_sel_i,
  output logic [W-1:0]        rd_data_o,
  output logic [NUM_CH*W-1:0] coef_o,
  output logic                wr_err_o
);
  localparam int unsigned DWELL_RAW = gcb_pkg::dwell_cycles(CLK_KHZ, DWELL_NS);
  localparam int unsigned DWELL_CYC = (DWELL_RAW < 1) ? 1 : DWELL_RAW;

  logic              qual;
  logic              dwell_ok;
  logic [NUM_CH-1:0] wr_hit;
  logic [W-1:0]      coef [NUM_CH];

  assign qual = cnv_en_i & cnv_idle_i;

  gcb_dwell_timer #(.DWELL_CYC(DWELL_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .qual_i    (qual),
    .dwell_ok_o(dwell_ok)
  );

  gcb_write_guard #(.NUM_CH(NUM_CH), .SW(SW)) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .qual_i    (qual),
    .dwell_ok_i(dwell_ok),
    .cal_done_i(cal_done_i),
    .wr_hit_o  (wr_hit),
    .wr_err_o  (wr_err_o)
  );

  for (genvar c = 0; c < int'(NUM_CH); c++) begin : g_ch
    gcb_coef_reg #(.W(W)) u_coef (
      .clk       (clk),
      .rst_n     (rst_n),
      .preset_i  (preset_i[c*W +: W]),
      .cal_done_i(cal_done_i[c]),
      .cal_data_i(cal_data_i[c*W +: W]),
      .wr_hit_i  (wr_hit[c]),
      .wr_data_i (wr_data_i),
      .coef_o    (coef[c])
    );
    assign coef_o[c*W +: W] = coef[c];
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < int'(NUM_CH); i++) begin
      if (rd_sel_i == SW'(i)) rd_data_o = coef[i];
    end
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    !rst_n |=> !wr_err_o);
endmodule

// File: tb/test_gain_cal_guard.sv
module test_gain_cal_guard;
  localparam int NCH = 3;
  localparam int DW  = (1000 * 8000 + 999_999) / 1_000_000; // ceil -> 8 cycles

  logic clk = 1'b0;
  logic rst_n;
  logic [NCH*16-1:0] preset;
  logic cnv_en, cnv_idle, wr_en;
  logic [1:0] wr_sel, rd_sel;
  logic [15:0] wr_data, rd_data;
  logic [NCH-1:0] cal_done;
  logic [NCH*16-1:0] cal_data, coef;
  logic wr_err;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [15:0] model [NCH];

  always #4 clk = ~clk;

  gain_cal_guard #(.NUM_CH(NCH), .CLK_KHZ(1000), .DWELL_NS(8000)) i_gain_cal_guard (
    .clk(clk), .rst_n(rst_n), .preset_i(preset), .cnv_en_i(cnv_en),
    .cnv_idle_i(cnv_idle), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .cal_done_i(cal_done), .cal_data_i(cal_data), .rd_sel_i(rd_sel),
    .rd_data_o(rd_data), .coef_o(coef), .wr_err_o(wr_err)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_bank(input string req);
    for (int c = 0; c < NCH; c++) begin
      chk(req, coef[c*16 +: 16], model[c]);
      rd_sel = 2'(c);
      #1;
      chk(req, rd_data, model[c]);
    end
  endtask

  task automatic do_write(input logic [1:0] sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic fresh_dwell(input int n);
    cnv_en = 1'b0; @(negedge clk);
    cnv_en = 1'b1; cnv_idle = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cnv_en = 1'b0; cnv_idle = 1'b0; wr_en = 1'b0;
    wr_sel = '0; wr_data = '0; rd_sel = '0; cal_done = '0; cal_data = '0;
    for (int c = 0; c < NCH; c++) begin
      preset[c*16 +: 16] = 16'hA000 + 16'(c * 16'h1011);
      model[c] = 16'hA000 + 16'(c * 16'h1011);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: presets loaded, no error
    chk_bank("R1");
    chk("R1", {15'd0, wr_err}, 16'd0);
    // R2: out-of-range readback is zero
    rd_sel = 2'd3; #1;
    chk("R2", rd_data, 16'h0000);

    // R5/R3/R4: dwell boundary sweep
    for (int n = 0; n <= 12; n++) begin
      logic [15:0] d;
      int ch;
      d = 16'h1000 + 16'(n * 16'h0111);
      ch = n % NCH;
      fresh_dwell(n);
      do_write(2'(ch), d);
      if (n >= DW) model[ch] = d;
      chk_bank(n >= DW ? "R3" : "R5");
      chk(n >= DW ? "R3" : "R5", {15'd0, wr_err}, {15'd0, (n < DW)});
      @(negedge clk);
      chk("R4", {15'd0, wr_err}, 16'd0);
    end

    // R4: converter disabled, and separately not idle
    cnv_en = 1'b0; cnv_idle = 1'b1;
    do_write(2'd1, 16'hDEAD);
    chk_bank("R4");
    chk("R4", {15'd0, wr_err}, 16'd1);
    fresh_dwell(20);
    cnv_idle = 1'b0;
    do_write(2'd2, 16'hBEEF);
    chk_bank("R4");
    chk("R4", {15'd0, wr_err}, 16'd1);

    // R6: one idle drop restarts the count
    fresh_dwell(20);
    cnv_idle = 1'b0; @(negedge clk); cnv_idle = 1'b1;
    repeat (DW - 1) @(negedge clk);
    do_write(2'd0, 16'h5A5A);
    chk_bank("R6");
    chk("R6", {15'd0, wr_err}, 16'd1);
    do_write(2'd0, 16'h5A5B);   // count has now reached the limit
    model[0] = 16'h5A5B;
    chk_bank("R6");
    chk("R6", {15'd0, wr_err}, 16'd0);

    // R9: select out of range
    do_write(2'd3, 16'h7777);
    chk_bank("R9");
    chk("R9", {15'd0, wr_err}, 16'd1);

    // R7: calibration lands with the converter disabled
    cnv_en = 1'b0;
    cal_done = 3'b010; cal_data[16 +: 16] = 16'hC0DE;
    @(negedge clk);
    cal_done = '0;
    model[1] = 16'hC0DE;
    chk_bank("R7");

    // R8: same-channel collision, calibration wins
    fresh_dwell(DW + 2);
    cal_done = 3'b100; cal_data[32 +: 16] = 16'hCA1B;
    do_write(2'd2, 16'h1111);
    cal_done = '0;
    model[2] = 16'hCA1B;
    chk_bank("R8");
    chk("R8", {15'd0, wr_err}, 16'd1);

    // R10: cross-channel collision, both land
    cal_done = 3'b001; cal_data[0 +: 16] = 16'h0CA1;
    do_write(2'd1, 16'h2222);
    cal_done = '0;
    model[0] = 16'h0CA1;
    model[1] = 16'h2222;
    chk_bank("R10");
    chk("R10", {15'd0, wr_err}, 16'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule